// File: doc/BRIEF.md
# Branch Condition and Delay-Slot Annul Unit

This block resolves control transfers for a pipeline with a single architectural delay slot. For a conditional branch it takes the four stored integer flags (negative, zero, overflow, carry), a 4-bit condition selector, an annul bit and a 22-bit signed word displacement. From these it reports whether the branch is taken, the byte target address, and whether the instruction in the delay slot must be squashed.

The unit also serves the PC-relative call, which carries a 30-bit word offset. A call is always taken and never squashes its delay slot. It also requests a write of the call's own address into link register 15. All outputs are purely combinational in the inputs, so the fetch stage can use them in the same cycle in which the branch is decoded.

Top module: `branch_resolve_unit`

## Requirements
- R1: `cond_i` selects the condition. Codes 0..7 are never, equal (Z), less-or-equal signed (Z or (N xor V)), less signed (N xor V), less-or-equal unsigned (C or Z), carry set (C), negative (N) and overflow set (V). Code 8 is always. Codes 9..15 are the complements of codes 1..7 in the same order: not equal, greater, greater-or-equal, greater unsigned, carry clear, positive, overflow clear.
- R2: With `is_branch_i`=1 and `is_call_i`=0, `taken_o` equals the selected condition.
- R3: For a branch, `target_o` = `pc_i` + sign-extended `br_disp_i` × 4, modulo 2^32. This gives a reach of -8 MB to +8 MB-4.
- R4: With `annul_i`=0, `squash_o` is 0.
- R5: For a branch with `annul_i`=1 and a condition code other than 0 or 8, `squash_o` is 1 exactly when the branch is not taken.
- R6: For a branch with `annul_i`=1 and condition code 8 (always) or 0 (never), `squash_o` is 1.
- R7: With `is_call_i`=1, `taken_o`=1, `squash_o`=0 and `target_o` = `pc_i` + `call_disp_i` × 4, modulo 2^32.
- R8: With `is_call_i`=1, `link_we_o`=1, `link_idx_o`=15 and `link_data_o`=`pc_i`. Otherwise `link_we_o`=0.
- R9: With neither `is_branch_i` nor `is_call_i` set, `taken_o`, `squash_o` and `link_we_o` are 0, whatever the values of `annul_i`, `cond_i` and the flags.
- R10: When `is_branch_i` and `is_call_i` are both 1, the call takes priority. The outputs are those of R7 and R8, and the branch condition and annul bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the control-transfer instruction |
| is_branch_i | input | 1 | Current instruction is a conditional branch |
| is_call_i | input | 1 | Current instruction is a PC-relative call |
| cond_i | input | 4 | Condition selector (R1 encoding) |
| annul_i | input | 1 | Annul bit of the branch |
| br_disp_i | input | 22 | Signed branch word displacement |
| call_disp_i | input | 30 | Call word displacement |
| flag_n_i | input | 1 | Stored negative flag |
| flag_z_i | input | 1 | Stored zero flag |
| flag_v_i | input | 1 | Stored overflow flag |
| flag_c_i | input | 1 | Stored carry flag |
| taken_o | output | 1 | Transfer is taken |
| target_o | output | 32 | Byte target address |
| squash_o | output | 1 | Delay-slot instruction must be squashed |
| link_we_o | output | 1 | Write request for the link register |
| link_idx_o | output | 5 | Link register index (15) |
| link_data_o | output | 32 | Return address value written to the link register |

## Verification
Hand-picked flag patterns alone can miss the conditions that depend on overflow. These are the signed orderings, where N xor V must disagree with N. Overflow is hard to produce through realistic flag values.

The bench therefore derives the flags from real 32-bit subtractions. It uses operand pairs that straddle the sign boundary, such as the largest positive value against a negative one. It then compares every one of the sixteen conditions against the native signed and unsigned comparison of the same operands. The displacement extremes at +8 MB-4 and -8 MB are driven with a PC near zero, so that the address wraps.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [3:0] {
    CND_NEVER  = 4'd0,
    CND_EQ     = 4'd1,
    CND_LE     = 4'd2,
    CND_LT     = 4'd3,
    CND_LEU    = 4'd4,
    CND_CS     = 4'd5,
    CND_NEG    = 4'd6,
    CND_VS     = 4'd7,
    CND_ALWAYS = 4'd8,
    CND_NE     = 4'd9,
    CND_GT     = 4'd10,
    CND_GE     = 4'd11,
    CND_GU     = 4'd12,
    CND_CC     = 4'd13,
    CND_POS    = 4'd14,
    CND_VC     = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // Base relation selected by the low three bits; bit 3 inverts it.
  function automatic logic base_relation(input logic [2:0] sel, input flags_t f);
    logic r;
    case (sel)
      3'd0:    r = 1'b0;
      3'd1:    r = f.z;
      3'd2:    r = f.z | (f.n ^ f.v);
      3'd3:    r = f.n ^ f.v;
      3'd4:    r = f.c | f.z;
      3'd5:    r = f.c;
      3'd6:    r = f.n;
      default: r = f.v;
    endcase
    return r;
  endfunction

  function automatic logic cond_holds(input cond_e code, input flags_t f);
    logic [3:0] raw;
    raw = code;
    return raw[3] ^ base_relation(raw[2:0], f);
  endfunction

  // Always and never share an all-zero low field.
  function automatic logic cond_is_uncond(input cond_e code);
    logic [3:0] raw;
    raw = code;
    return (raw[2:0] == 3'd0);
  endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
(
  input  cond_e  code_i,
  input  flags_t flags_i,
  output logic   holds_o,
  output logic   uncond_o
);

  always_comb begin
    holds_o  = cond_holds(code_i, flags_i);
    uncond_o = cond_is_uncond(code_i);
  end

  // A code and its complement never agree (R1).
  logic mirror_holds;
  always_comb begin
    mirror_holds = cond_holds(cond_e'(code_i ^ 4'b1000), flags_i);
    assert_complement_pair_R1: assert (mirror_holds != holds_o);
  end

endmodule

// File: rtl/bru_target_add.sv
module bru_target_add #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 22
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);

  localparam int SH_W = DISP_W + 2;

  logic [SH_W-1:0]   byte_off;
  logic [ADDR_W-1:0] off_ext;

  assign byte_off = {disp_i, 2'b00};

  generate
    if (SH_W >= ADDR_W) begin : g_trunc
      assign off_ext = byte_off[ADDR_W-1:0];
    end else begin : g_sext
      assign off_ext = {{(ADDR_W-SH_W){byte_off[SH_W-1]}}, byte_off};
    end
  endgenerate

  assign target_o = pc_i + off_ext;

endmodule

// File: rtl/bru_annul_ctrl.sv
module bru_annul_ctrl (
  input  logic br_active_i,
  input  logic annul_i,
  input  logic uncond_i,
  input  logic cond_true_i,
  output logic squash_o
);

  assign squash_o = br_active_i & annul_i & (uncond_i | ~cond_true_i);

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BR_DISP_W   = 22,
  parameter int CALL_DISP_W = 30,
  parameter int REG_IDX_W   = 5,
  parameter int LINK_REG    = 15
) (
  input  logic [ADDR_W-1:0]      pc_i,
  input  logic                   is_branch_i,
  input  logic                   is_call_i,
  input  logic [3:0]             cond_i,
  input  logic                   annul_i,
  input  logic [BR_DISP_W-1:0]   br_disp_i,
  input  logic [CALL_DISP_W-1:0] call_disp_i,
  input  logic                   flag_n_i,
  input  logic                   flag_z_i,
  input  logic                   flag_v_i,
  input  logic                   flag_c_i,
  output logic                   taken_o,
  output logic [ADDR_W-1:0]      target_o,
  output logic                   squash_o,
  output logic                   link_we_o,
  output logic [REG_IDX_W-1:0]   link_idx_o,
  output logic [ADDR_W-1:0]      link_data_o
);

  flags_t            flags;
  logic              br_active;
  logic              cond_true;
  logic              cond_uncond;
  logic              br_squash;
  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] call_target;

  assign flags     = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};
  assign br_active = is_branch_i & ~is_call_i;

  bru_cond_eval u_cond (
    .code_i   (cond_e'(cond_i)),
    .flags_i  (flags),
    .holds_o  (cond_true),
    .uncond_o (cond_uncond)
  );

  bru_target_add #(.ADDR_W(ADDR_W), .DISP_W(BR_DISP_W)) u_br_add (
    .pc_i     (pc_i),
    .disp_i   (br_disp_i),
    .target_o (br_target)
  );

  bru_target_add #(.ADDR_W(ADDR_W), .DISP_W(CALL_DISP_W)) u_call_add (
    .pc_i     (pc_i),
    .disp_i   (call_disp_i),
    .target_o (call_target)
  );

  bru_annul_ctrl u_annul (
    .br_active_i (br_active),
    .annul_i     (annul_i),
    .uncond_i    (cond_uncond),
    .cond_true_i (cond_true),
    .squash_o    (br_squash)
  );

  assign taken_o     = is_call_i | (br_active & cond_true);
  assign target_o    = is_call_i ? call_target : br_target;
  assign squash_o    = br_squash;
  assign link_we_o   = is_call_i;
  assign link_idx_o  = REG_IDX_W'(LINK_REG);
  assign link_data_o = pc_i;

  always_comb begin
    if (!annul_i) begin
      assert_plain_slot_runs_R4: assert (!squash_o);
    end
    if (is_call_i) begin
      assert_call_keeps_slot_R7: assert (taken_o && !squash_o);
    end
    if (!is_branch_i && !is_call_i) begin
      assert_idle_quiet_R9: assert (!taken_o && !squash_o && !link_we_o);
    end
    if (br_active && annul_i && !cond_uncond) begin
      assert_annul_follows_outcome_R5: assert (squash_o != taken_o);
    end
    assert_target_word_aligned_R3: assert (target_o[1:0] == pc_i[1:0]);
  end

endmodule

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc;
  logic        is_branch, is_call, annul;
  logic [3:0]  cond;
  logic [21:0] br_disp;
  logic [29:0] call_disp;
  logic        fn, fz, fv, fc;
  logic        taken, squash, link_we;
  logic [31:0] target, link_data;
  logic [4:0]  link_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  branch_resolve_unit uut (
    .pc_i(pc), .is_branch_i(is_branch), .is_call_i(is_call), .cond_i(cond),
    .annul_i(annul), .br_disp_i(br_disp), .call_disp_i(call_disp),
    .flag_n_i(fn), .flag_z_i(fz), .flag_v_i(fv), .flag_c_i(fc),
    .taken_o(taken), .target_o(target), .squash_o(squash),
    .link_we_o(link_we), .link_idx_o(link_idx), .link_data_o(link_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_br(input logic [31:0] p, input logic [21:0] d);
    longint s = longint'(d);
    if (d[21]) s = s - 64'sd4194304;
    return 32'(longint'(p) + s * 4);
  endfunction

  function automatic logic [31:0] exp_call(input logic [31:0] p, input logic [29:0] d);
    return 32'(longint'(p) + longint'(d) * 4);
  endfunction

  // {cond, annul, nzvc, expected taken, expected squash}
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    {4'd1,  1'b0, 4'b0100, 1'b1, 1'b0},
    {4'd1,  1'b1, 4'b0000, 1'b0, 1'b1},
    {4'd9,  1'b1, 4'b0000, 1'b1, 1'b0},
    {4'd3,  1'b0, 4'b1000, 1'b1, 1'b0},
    {4'd3,  1'b1, 4'b1010, 1'b0, 1'b1},
    {4'd2,  1'b1, 4'b0100, 1'b1, 1'b0},
    {4'd10, 1'b0, 4'b1010, 1'b1, 1'b0},
    {4'd11, 1'b1, 4'b1000, 1'b0, 1'b1},
    {4'd4,  1'b0, 4'b0001, 1'b1, 1'b0},
    {4'd12, 1'b1, 4'b0000, 1'b1, 1'b0},
    {4'd12, 1'b1, 4'b0100, 1'b0, 1'b1},
    {4'd5,  1'b1, 4'b0001, 1'b1, 1'b0},
    {4'd13, 1'b1, 4'b0001, 1'b0, 1'b1},
    {4'd6,  1'b0, 4'b1000, 1'b1, 1'b0},
    {4'd14, 1'b0, 4'b1000, 1'b0, 1'b0},
    {4'd7,  1'b1, 4'b0010, 1'b1, 1'b0},
    {4'd15, 1'b1, 4'b0010, 1'b0, 1'b1},
    {4'd8,  1'b0, 4'b0000, 1'b1, 1'b0},
    {4'd8,  1'b1, 4'b0000, 1'b1, 1'b1},
    {4'd0,  1'b0, 4'b1111, 1'b0, 1'b0},
    {4'd0,  1'b1, 4'b0000, 1'b0, 1'b1}
  };

  task automatic idle();
    pc = 32'h0; is_branch = 0; is_call = 0; annul = 0; cond = 4'd0;
    br_disp = '0; call_disp = '0; {fn, fz, fv, fc} = 4'b0000;
  endtask

  initial begin
    idle();
    @(negedge clk);
    // Idle state after reset: R9
    check("R9 taken idle", {31'd0, taken}, 32'd0);
    check("R9 squash idle", {31'd0, squash}, 32'd0);
    check("R8 link_we idle", {31'd0, link_we}, 32'd0);

    // Idle with annul and a false condition still quiet: R9
    @(posedge clk);
    annul = 1; cond = 4'd1; {fn, fz, fv, fc} = 4'b0000;
    @(negedge clk);
    check("R9 squash with annul, no branch", {31'd0, squash}, 32'd0);

    // Table: R1 R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      idle();
      is_branch = 1; pc = 32'h0000_4000;
      cond = VEC[i][10:7]; annul = VEC[i][6]; {fn, fz, fv, fc} = VEC[i][5:2];
      @(negedge clk);
      check($sformatf("R2 taken vec %0d", i), {31'd0, taken}, {31'd0, VEC[i][1]});
      check($sformatf("R5 R6 squash vec %0d", i), {31'd0, squash}, {31'd0, VEC[i][0]});
    end

    // Flags from real subtractions against native compares: R1
    begin
      logic [31:0] av [8] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 32'h5,
                              32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234};
      logic [31:0] bv [8] = '{32'hFFFF_FFFF, 32'h1, 32'h0, 32'h7,
                              32'h1, 32'h8000_0000, 32'h8000_0000, 32'h1233};
      for (int p = 0; p < 8; p++) begin
        for (int k = 0; k < 16; k++) begin
          logic [31:0] a, b, r;
          logic base, want;
          a = av[p]; b = bv[p]; r = a - b;
          case (k % 8)
            0: base = 1'b0;
            1: base = (a == b);
            2: base = ($signed(a) <= $signed(b));
            3: base = ($signed(a) < $signed(b));
            4: base = (a <= b);
            5: base = (a < b);
            6: base = r[31];
            default: base = (a[31] != b[31]) && (r[31] != a[31]);
          endcase
          want = (k >= 8) ? ~base : base;
          @(posedge clk);
          idle();
          is_branch = 1; cond = 4'(k);
          fn = r[31]; fz = (r == 0); fc = (a < b);
          fv = (a[31] != b[31]) && (r[31] != a[31]);
          @(negedge clk);
          check($sformatf("R1 cond %0d pair %0d", k, p), {31'd0, taken}, {31'd0, want});
        end
      end
    end

    // Branch targets incl. reach limits and wrap: R3
    begin
      logic [31:0] pcs [4] = '{32'h0000_1000, 32'h0000_0008, 32'hFFFF_FFF0, 32'h8000_0000};
      logic [21:0] ds  [5] = '{22'h1F_FFFF, 22'h20_0000, 22'h0, 22'h1, 22'h3F_FFFF};
      for (int p = 0; p < 4; p++) begin
        for (int d = 0; d < 5; d++) begin
          @(posedge clk);
          idle();
          is_branch = 1; cond = 4'd8; pc = pcs[p]; br_disp = ds[d];
          @(negedge clk);
          check($sformatf("R3 target pc%0d d%0d", p, d), target, exp_br(pcs[p], ds[d]));
        end
      end
    end

    // Calls: R7 R8
    begin
      logic [29:0] cds [3] = '{30'h3FFF_FFFF, 30'h1, 30'h2000_0000};
      for (int d = 0; d < 3; d++) begin
        @(posedge clk);
        idle();
        is_call = 1; pc = 32'h0040_0010; call_disp = cds[d];
        @(negedge clk);
        check("R7 call taken", {31'd0, taken}, 32'd1);
        check("R7 call squash", {31'd0, squash}, 32'd0);
        check("R7 call target", target, exp_call(32'h0040_0010, cds[d]));
        check("R8 link_we", {31'd0, link_we}, 32'd1);
        check("R8 link_idx", {27'd0, link_idx}, 32'd15);
        check("R8 link_data", link_data, 32'h0040_0010);
      end
    end

    // Branch and call together, with annul and false condition: R10
    @(posedge clk);
    idle();
    is_branch = 1; is_call = 1; annul = 1; cond = 4'd0; pc = 32'h100;
    br_disp = 22'h5; call_disp = 30'h40;
    @(negedge clk);
    check("R10 priority taken", {31'd0, taken}, 32'd1);
    check("R10 priority squash", {31'd0, squash}, 32'd0);
    check("R10 priority target", target, 32'h200);
    check("R10 priority link_we", {31'd0, link_we}, 32'd1);

    // Annul clear on false branch never squashes: R4
    @(posedge clk);
    idle();
    is_branch = 1; cond = 4'd1; annul = 0;
    @(negedge clk);
    check("R4 no squash", {31'd0, squash}, 32'd0);
    check("R8 no link on branch", {31'd0, link_we}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule